// File: doc/BRIEF.md
# UART Transmitter with Wide-Mode Unpacking

This block is the transmit engine of a serial port. It pops characters from a show-ahead transmit FIFO and sends them on one TX line. Each frame is a start bit, the data bits with the least significant bit first, an optional parity bit that the block generates, and one or two stop bits. The bit rate comes from a baud tick input that pulses at sixteen times the bit rate. Each bit therefore lasts a fixed number of ticks.

Static configuration inputs set the character length (5, 6, 7, 8 or 9 bits), parity enable and sense, the stop-bit count and wide mode.

- When 9 bits are selected without wide mode, only the low eight bits of each FIFO byte reach the line.
- When 9 bits are selected with wide mode, two consecutive FIFO bytes form one character. The first byte gives bits 7..0, and bit 0 of the second byte gives bit 8.
- Parity is never generated for 9-bit characters.

A new character is taken from the FIFO only when the shift register has finished the previous one.

Top module: `uart_wide_tx`

## Requirements
- R1: After reset, txOut is high, busy is low and fifoRd is low. While busy is low, txOut stays high.
- R2: A frame on txOut is a start bit of 0, then the data bits with the least significant bit first, then the parity bit if one is sent, then stop bits of 1.
- R3: cfgLen codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, taken from fifoData bits 0 upward. FIFO bits above the selected length do not appear on the line.
- R4: With cfgLen 0 to 3 and cfgParEn high, one parity bit follows the data. With cfgParOdd at 0, the data bits plus the parity bit hold an even number of ones; with cfgParOdd at 1, they hold an odd number.
- R5: With cfgTwoStop at 0 the frame ends with one stop bit; with cfgTwoStop at 1 it ends with two.
- R6: cfgLen code 4 (9-bit) with cfgWide low takes one FIFO byte per character and sends its 8 bits. It sends no parity bit, whatever cfgParEn is.
- R7: cfgLen code 4 with cfgWide high takes two FIFO bytes per character. The first byte gives data bits 7..0, bit 0 of the second byte gives data bit 8, and the other bits of the second byte are ignored. The frame is a start bit, 9 data bits and the stop bits, with no parity bit.
- R8: With cfgLen 0 to 3, cfgWide has no effect: one FIFO byte is taken per character.
- R9: Every bit on txOut lasts OVERSAMPLE baudTick pulses. The start bit begins in the clock cycle after the cycle in which the character's last FIFO byte is read.
- R10: fifoRd is a single-cycle pop that is driven only while fifoEmpty is low, and never while busy is high. In wide mode the block waits, with the line idle, for the second byte of a pair.
- R11: busy rises when the start bit is launched and stays high until the last stop bit has lasted its full time. It then falls with txOut high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| cfgLen | input | 3 | Character length code: 0..3 = 5..8 bits, 4 = 9 bits |
| cfgParEn | input | 1 | Generate a parity bit (5 to 8 bit lengths only) |
| cfgParOdd | input | 1 | Parity sense: 0 even, 1 odd |
| cfgTwoStop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| cfgWide | input | 1 | Build 9-bit characters from FIFO byte pairs |
| fifoEmpty | input | 1 | FIFO has no entry |
| fifoData | input | 8 | Head entry of the show-ahead FIFO |
| fifoRd | output | 1 | Pop the FIFO head in this cycle |
| txOut | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |

## Verification
The bench first sends bytes whose upper bits are set in 5, 6 and 7 bit modes; a design that did not mask them would send the wrong bits or the wrong parity. It then selects 9-bit mode without wide mode while parity is enabled; a design that got this wrong would add a parity bit or send a ninth bit. Wide pairs are sent with second bytes that carry junk in bits 7..1. One pair arrives with a long gap before its second byte, which a design that did not wait for the second byte would turn into a garbled or early frame. Finally, bursts sent back to back, together with a check on when busy falls, catch a design that reloads the shift register before the last stop bit ends or that sizes its bit periods wrongly.

// File: rtl/uart_wide_tx_pkg.sv
package uart_wide_tx_pkg;

  // Character length code for 9-bit characters; codes 0..3 are 5..8 bits.
  localparam logic [2:0] LEN_NINE = 3'd4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PAIR = 1'b1
  } txStateT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capLow;   // hold fifoData as the low byte of a wide pair
    logic load;     // build a frame and start shifting it
    logic useHeld;  // load: low byte from holding reg, bit 8 from fifoData[0]
  } txStrobeT;

endpackage

// File: rtl/uart_wide_tx_ctrl.sv
module uart_wide_tx_ctrl
  import uart_wide_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgLen,
  input  logic       cfgWide,
  input  logic       fifoEmpty,
  input  logic       busy,
  output logic       fifoRd,
  output txStrobeT   strobe
);

  txStateT state, stateNext;
  logic    wideNine;

  assign wideNine = cfgWide && (cfgLen == LEN_NINE);

  always_comb begin
    stateNext = state;
    fifoRd    = 1'b0;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        // Only start a character once the shifter has finished.
        if (!busy && !fifoEmpty) begin
          fifoRd = 1'b1;
          if (wideNine) begin
            strobe.capLow = 1'b1;
            stateNext     = ST_PAIR;
          end else begin
            strobe.load = 1'b1;
          end
        end
      end
      ST_PAIR: begin
        // Wait, line idle, for the byte carrying bit 8.
        if (!fifoEmpty) begin
          fifoRd         = 1'b1;
          strobe.load    = 1'b1;
          strobe.useHeld = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/uart_wide_tx_dp.sv
module uart_wide_tx_dp
  import uart_wide_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [2:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgTwoStop,
  input  logic [DATA_W-1:0] fifoData,
  input  txStrobeT          strobe,
  output logic              busy,
  output logic              txOut
);

  localparam int NINE_W  = DATA_W + 1;
  localparam int FRAME_W = 1 + NINE_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int TICK_W  = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int LEN_W   = $clog2(NINE_W + 1);

  logic [DATA_W-1:0]  heldByte;
  logic [NINE_W-1:0]  dataBits;
  logic [NINE_W-1:0]  dataMask;
  logic [LEN_W-1:0]   nData;
  logic               parOn;
  logic               parBit;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frameLen;

  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitsLeft;
  logic [TICK_W-1:0]  tickCnt;
  logic               bitEnd;

  // Holding register for the low byte of a wide pair.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              heldByte <= '0;
    else if (strobe.capLow) heldByte <= fifoData;
  end

  // Character assembly, parity and stop insertion.
  always_comb begin
    if (strobe.useHeld) dataBits = {fifoData[0], heldByte};
    else                dataBits = {1'b0, fifoData};

    if (cfgLen < LEN_NINE)    nData = LEN_W'(5) + LEN_W'(cfgLen);
    else if (strobe.useHeld)  nData = LEN_W'(NINE_W);
    else                      nData = LEN_W'(DATA_W);

    dataMask = NINE_W'(((NINE_W+1)'(1)) << nData) - NINE_W'(1);
    parOn    = cfgParEn && (cfgLen < LEN_NINE);
    parBit   = (^(dataBits & dataMask)) ^ cfgParOdd;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < NINE_W; i++) begin
      if (i < int'(nData)) frame[i+1] = dataBits[i];
    end
    if (parOn) frame[int'(nData) + 1] = parBit;

    frameLen = CNT_W'(1) + CNT_W'(nData) + CNT_W'(parOn)
             + (cfgTwoStop ? CNT_W'(2) : CNT_W'(1));
  end

  assign bitEnd = baudTick && (tickCnt == TICK_W'(OVERSAMPLE - 1));

  // Shift register and bit timing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      tickCnt  <= '0;
    end else if (strobe.load) begin
      shiftReg <= frame;
      bitsLeft <= frameLen;
      tickCnt  <= '0;
    end else if (bitsLeft != '0 && baudTick) begin
      if (bitEnd) begin
        tickCnt  <= '0;
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        bitsLeft <= bitsLeft - CNT_W'(1);
      end else begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end

  assign txOut = shiftReg[0];
  assign busy  = (bitsLeft != '0);

endmodule

// File: rtl/uart_wide_tx.sv
module uart_wide_tx
  import uart_wide_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [2:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgTwoStop,
  input  logic              cfgWide,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoRd,
  output logic              txOut,
  output logic              busy
);

  txStrobeT strobe;

  uart_wide_tx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLen   (cfgLen),
    .cfgWide  (cfgWide),
    .fifoEmpty(fifoEmpty),
    .busy     (busy),
    .fifoRd   (fifoRd),
    .strobe   (strobe)
  );

  uart_wide_tx_dp #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgParOdd (cfgParOdd),
    .cfgTwoStop(cfgTwoStop),
    .fifoData  (fifoData),
    .strobe    (strobe),
    .busy      (busy),
    .txOut     (txOut)
  );

endmodule

// File: rtl/uart_wide_tx_chk.sv
module uart_wide_tx_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic fifoEmpty,
  input logic fifoRd,
  input logic txOut,
  input logic busy
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);                                            // R10

  AST_NO_RD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !fifoRd);                                                 // R10

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);                                                  // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(busy)) |-> !txOut);                            // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && busy && $past(busy) && !$past(baudTick)) |-> $stable(txOut)); // R9

  AST_END_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(busy)) |-> txOut);                             // R11

endmodule

bind uart_wide_tx uart_wide_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .fifoEmpty(fifoEmpty),
  .fifoRd   (fifoRd),
  .txOut    (txOut),
  .busy     (busy)
);

// File: tb/uart_wide_tx_tb.sv
`timescale 1ns/1ps
module uart_wide_tx_tb;

  localparam int OVS     = 16;
  localparam int BIT_CYC = OVS * 2;   // baudTick every other cycle

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [2:0] cfgLen = 3'd3;
  logic       cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgTwoStop = 1'b0, cfgWide = 1'b0;
  logic       fifoEmpty;
  logic [7:0] fifoData;
  logic       fifoRd, txOut, busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  // Show-ahead FIFO model.
  logic [7:0] mem [0:15];
  logic [3:0] wrPtr = '0;
  logic [3:0] rdPtr = '0;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoData  = mem[rdPtr];
  always @(posedge clk) if (fifoRd) rdPtr <= rdPtr + 4'd1;

  always @(negedge clk) baudTick <= ~baudTick;

  uart_wide_tx #(.OVERSAMPLE(OVS), .DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgTwoStop(cfgTwoStop), .cfgWide(cfgWide),
    .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoRd(fifoRd), .txOut(txOut), .busy(busy)
  );

  typedef struct {
    logic [15:0] bits;
    int          n;
    string       tag;
  } expFrameT;

  expFrameT sb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    mem[wrPtr] = b;
    wrPtr = wrPtr + 4'd1;
  endtask

  // Expected frame from the requirements, for the current configuration.
  task automatic expectChar(input logic [8:0] d, input string tag);
    expFrameT e;
    int n, ones;
    bit par;
    e.bits = '1; e.n = 0; e.tag = tag;
    if (cfgLen == 3'd4) begin
      n = cfgWide ? 9 : 8;       // R6 R7
      par = 1'b0;
    end else begin
      n = 5 + int'(cfgLen);      // R3
      par = cfgParEn;            // R4
    end
    e.bits[e.n++] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      e.bits[e.n++] = d[i];
      ones += int'(d[i]);
    end
    if (par) e.bits[e.n++] = cfgParOdd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    e.bits[e.n++] = 1'b1;
    if (cfgTwoStop) e.bits[e.n++] = 1'b1;  // R5
    sb.push_back(e);
  endtask

  task automatic sendNarrow(input logic [7:0] b, input string tag);
    expectChar({1'b0, b}, tag);
    pushByte(b);
  endtask

  task automatic sendWide(input logic [7:0] lo, input logic [7:0] hi, input string tag);
    expectChar({hi[0], lo}, tag);
    pushByte(lo);
    pushByte(hi);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (sb.size() != 0 || !fifoEmpty || busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setCfg(input logic [2:0] len, input bit pe, input bit po,
                        input bit ts, input bit wide);
    @(negedge clk);
    cfgLen = len; cfgParEn = pe; cfgParOdd = po; cfgTwoStop = ts; cfgWide = wide;
  endtask

  // Monitor: decodes frames at bit centres and compares against the queue.
  initial begin
    expFrameT e;
    logic [15:0] got;
    int endCyc;
    bit busyOk;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      while (txOut !== 1'b0) @(negedge clk);
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected frame", 0, 1);
        while (busy) @(negedge clk);
      end else begin
        e = sb.pop_front();
        got = '1;
        busyOk = 1'b1;
        repeat (BIT_CYC/2) @(negedge clk);
        for (int k = 0; k < e.n; k++) begin
          if (k > 0) repeat (BIT_CYC) @(negedge clk);
          got[k] = txOut;
          if (busy !== 1'b1) busyOk = 1'b0;
        end
        check(got == e.bits, e.tag, "frame bits (R2)", int'(got), int'(e.bits));
        check(busyOk, "R11", "busy high through frame", int'(busyOk), 1);
        endCyc = 0;
        while (busy === 1'b1 && endCyc < 100) begin
          @(negedge clk);
          endCyc++;
        end
        // Mid last bit to busy fall is half a bit period (R9 R11).
        check(endCyc >= BIT_CYC/2 - 2 && endCyc <= BIT_CYC/2 + 2, "R9",
              "cycles from last bit centre to busy fall", endCyc, BIT_CYC/2);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    int readCnt;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(txOut === 1'b1, "R1", "txOut in reset", int'(txOut), 1);
    check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(fifoRd === 1'b0, "R1", "fifoRd in reset", int'(fifoRd), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txOut === 1'b1 && busy === 1'b0, "R1", "idle after reset",
          int'({txOut, busy}), 2);

    // R2 R3: 8 data bits, no parity, one stop
    setCfg(3'd3, 0, 0, 0, 0);
    sendNarrow(8'hA5, "R2");
    sendNarrow(8'h3C, "R3");
    waitIdle();

    // R4: 8 bits even parity
    setCfg(3'd3, 1, 0, 0, 0);
    sendNarrow(8'h01, "R4");
    sendNarrow(8'hFF, "R4");
    waitIdle();

    // R3 R4 R5: 7 bits odd parity two stops, bit 7 set must be ignored
    setCfg(3'd2, 1, 1, 1, 0);
    sendNarrow(8'hF1, "R3");
    sendNarrow(8'h80, "R5");
    waitIdle();

    // R3 R4: 5 bits even parity, upper bits set
    setCfg(3'd0, 1, 0, 0, 0);
    sendNarrow(8'hE6, "R3");
    sendNarrow(8'hFF, "R4");
    waitIdle();

    // R5: 6 bits, no parity, two stops
    setCfg(3'd1, 0, 0, 1, 0);
    sendNarrow(8'hC5, "R5");
    waitIdle();

    // R6: 9-bit without wide mode, parity request has no effect
    setCfg(3'd4, 1, 0, 0, 0);
    sendNarrow(8'h96, "R6");
    sendNarrow(8'h01, "R6");
    waitIdle();

    // R7: wide pairs, junk in upper bits of second byte
    setCfg(3'd4, 1, 1, 0, 1);
    sendWide(8'h5A, 8'hFE, "R7");
    sendWide(8'h00, 8'h01, "R7");
    waitIdle();

    // R7 R10: second byte of pair delayed; line must stay idle meanwhile
    expectChar({1'b1, 8'hC3}, "R7");
    pushByte(8'hC3);
    repeat (200) @(negedge clk);
    check(txOut === 1'b1 && busy === 1'b0, "R10", "idle while pair incomplete",
          int'({txOut, busy}), 2);
    pushByte(8'h03);
    waitIdle();

    // R8: wide set with 8-bit length, one byte per character
    setCfg(3'd3, 1, 1, 1, 1);
    sendNarrow(8'h33, "R8");
    sendNarrow(8'h34, "R8");
    waitIdle();

    // R10: back-to-back burst, one pop per character
    setCfg(3'd3, 0, 0, 0, 0);
    readCnt = int'(rdPtr);
    for (int i = 0; i < 4; i++) sendNarrow(8'(8'h11 * (i + 1)), "R10");
    waitIdle();
    check(int'(4'(rdPtr - 4'(readCnt))) == 4, "R10", "pops for burst",
          int'(4'(rdPtr - 4'(readCnt))), 4);
    check(busy === 1'b0 && txOut === 1'b1, "R11", "idle at end",
          int'({busy, txOut}), 1);

    finishRun();
  end

endmodule